// File: doc/BRIEF.md
# Address Translation Result Register

This block sits between software-visible control writes and an external address translation unit. Software writes a 32-bit virtual address to one of four operation slots. The slot index picks the privilege level and the access type of the probe. The block then issues one lookup request through a valid/ready handshake. It waits for the single response and folds the outcome into a 32-bit result register.

On success, the result register holds the page-frame bits of the physical address and the returned memory attributes, with bit 0 clear. On a fault, bit 0 is set and the fault status is packed into the low bits. Slot indices outside the four supported ones belong to an unsupported security world. A write to one of them raises an error pulse and issues no request.

While a lookup is in flight, the block reports busy and ignores further operation writes. Software may also load the result register directly, but only while the block is idle.

Top module: `xrr_top`

## Requirements
- R1: Operation slot index encoding is index[0] = write access and index[1] = user privilege, for indices 0 to 3. An accepted write raises `req_valid` in the following cycle, together with the captured address and flags. `req_valid` stays high with stable fields until `req_ready` is sampled high.
- R2: An operation write with index 4 to 7 while idle pulses `op_err` for exactly the following cycle. It raises no request, does not set busy, and leaves `res_q` unchanged.
- R3: A successful response (`rsp_fault` = 0) makes `res_q` equal to {rsp_paddr[31:12], rsp_attr[10:0], 1'b0}, in the cycle after the response is sampled.
- R4: A fault response makes `res_q` equal to {25'b0, rsp_ext, rsp_fs_hi, rsp_fs_lo[3:0], 1'b1}. That is bit 6 = external abort, bit 5 = high status bit, bits 4:1 = low status bits, bit 0 = 1. It appears in the cycle after the response is sampled.
- R5: While a lookup is outstanding, `res_q` does not change until the response is sampled.
- R6: `busy` is high from the cycle after an accepted operation write until the cycle after the response. Operation writes seen while busy are dropped: they cause no `op_err` and no later request.
- R7: `res_wr` while idle loads `res_wdata` into `res_q` in the next cycle. `res_wr` while busy is ignored.
- R8: Asserting `rst_n` low at once clears `res_q`, `busy`, `req_valid` and `op_err`, and drops any pending request.
- R9: `rsp_valid` while no lookup is waiting for a response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr_valid | input | 1 | Write to an operation slot |
| op_wr_idx | input | 3 | Operation slot index |
| op_wr_addr | input | 32 | Virtual address written |
| op_err | output | 1 | One-cycle pulse: unsupported slot index |
| busy | output | 1 | Lookup outstanding |
| req_valid | output | 1 | Lookup request valid |
| req_ready | input | 1 | Translation unit accepts request |
| req_vaddr | output | 32 | Virtual address to translate |
| req_user | output | 1 | 1 = user privilege, 0 = privileged |
| req_write | output | 1 | 1 = write access, 0 = read access |
| rsp_valid | input | 1 | Translation response valid |
| rsp_paddr | input | 32 | Translated physical address |
| rsp_attr | input | 11 | Memory attribute bits |
| rsp_fault | input | 1 | Translation faulted |
| rsp_ext | input | 1 | Fault was an external abort |
| rsp_fs_hi | input | 1 | High fault status bit |
| rsp_fs_lo | input | 4 | Low fault status bits |
| res_wr | input | 1 | Direct write to result register |
| res_wdata | input | 32 | Direct write data |
| res_q | output | 32 | Result register contents |

## Verification
The bench goes after the packing of both outcomes. Swapped or shifted fault fields would put the external-abort or status bits in the wrong positions, and a success path that leaked the low address bits would corrupt the attribute field. Operation writes and direct result writes are injected while a lookup is outstanding. A design that did not hold them off would launch a second request or overwrite the result before the response. Unsupported indices, stray responses while idle, a long-stalled `req_ready` and a reset in the middle of a request are also driven. These expose error pulses that are missing or repeated, requests that are spurious or dropped, and state that survives a reset.

// File: rtl/xrr_pkg.sv
package xrr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xrr_state_e;

  typedef struct packed {
    logic supported;
    logic user;
    logic write;
  } xrr_op_t;

  localparam int FAULT_W = 7;

  // Fault code: ext at 6, high status at 5, low status at 4:1, flag at 0
  function automatic logic [FAULT_W-1:0] pack_fault(
    input logic       ext,
    input logic       fs_hi,
    input logic [3:0] fs_lo
  );
    return {ext, fs_hi, fs_lo, 1'b1};
  endfunction

endpackage

// File: rtl/xrr_op_decode.sv
module xrr_op_decode
  import xrr_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int NUM_OPS = 4
) (
  input  logic [IDX_W-1:0] idx,
  output xrr_op_t          op
);
  always_comb begin
    op.supported = (idx < IDX_W'(NUM_OPS));
    op.write     = idx[0];
    op.user      = idx[1];
  end
endmodule

// File: rtl/xrr_seq.sv
module xrr_seq
  import xrr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  xrr_op_t           op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_vaddr,
  output logic              req_user,
  output logic              req_write,
  output logic              busy,
  output logic              rsp_take,
  output logic              op_err
);
  xrr_state_e        st_q, st_d;
  logic              cap_en;
  logic              err_d;
  logic [ADDR_W-1:0] vaddr_q;
  logic              user_q, write_q, err_q;

  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    err_d    = 1'b0;
    rsp_take = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (op_valid) begin
          if (op.supported) begin
            st_d   = ST_REQ;
            cap_en = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_REQ: begin
        if (req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          rsp_take = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (cap_en) begin
      vaddr_q <= op_addr;
      user_q  <= op.user;
      write_q <= op.write;
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign req_vaddr = vaddr_q;
  assign req_user  = user_q;
  assign req_write = write_q;
  assign op_err    = err_q;
endmodule

// File: rtl/xrr_result.sv
module xrr_result
  import xrr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rsp_take,
  input  logic [ADDR_W-1:0]    rsp_paddr,
  input  logic [PAGE_BITS-2:0] rsp_attr,
  input  logic                 rsp_fault,
  input  logic                 rsp_ext,
  input  logic                 rsp_fs_hi,
  input  logic [3:0]           rsp_fs_lo,
  input  logic                 sw_wr,
  input  logic [ADDR_W-1:0]    sw_data,
  input  logic                 busy,
  output logic [ADDR_W-1:0]    res_q
);
  localparam int PAD_W = ADDR_W - FAULT_W;

  logic              load_en;
  logic [ADDR_W-1:0] res_d;
  logic [ADDR_W-1:0] ok_word;
  logic [ADDR_W-1:0] flt_word;

  always_comb begin
    ok_word  = {rsp_paddr[ADDR_W-1:PAGE_BITS], rsp_attr, 1'b0};
    flt_word = {{PAD_W{1'b0}}, pack_fault(rsp_ext, rsp_fs_hi, rsp_fs_lo)};
    load_en  = 1'b0;
    res_d    = res_q;
    if (rsp_take) begin
      load_en = 1'b1;
      res_d   = rsp_fault ? flt_word : ok_word;
    end else if (sw_wr && !busy) begin
      load_en = 1'b1;
      res_d   = sw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (load_en) res_q <= res_d;
  end
endmodule

// File: rtl/xrr_top.sv
module xrr_top
  import xrr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 3,
  parameter int NUM_OPS   = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_wr_valid,
  input  logic [IDX_W-1:0]     op_wr_idx,
  input  logic [ADDR_W-1:0]    op_wr_addr,
  output logic                 op_err,
  output logic                 busy,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_vaddr,
  output logic                 req_user,
  output logic                 req_write,
  input  logic                 rsp_valid,
  input  logic [ADDR_W-1:0]    rsp_paddr,
  input  logic [PAGE_BITS-2:0] rsp_attr,
  input  logic                 rsp_fault,
  input  logic                 rsp_ext,
  input  logic                 rsp_fs_hi,
  input  logic [3:0]           rsp_fs_lo,
  input  logic                 res_wr,
  input  logic [ADDR_W-1:0]    res_wdata,
  output logic [ADDR_W-1:0]    res_q
);
  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  xrr_op_t             op_dec;
  logic                rsp_take;

  // Reset asserts asynchronously, releases after SYNC_LEN edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  xrr_op_decode #(.IDX_W(IDX_W), .NUM_OPS(NUM_OPS)) u_dec (
    .idx (op_wr_idx),
    .op  (op_dec)
  );

  xrr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .op_valid  (op_wr_valid),
    .op        (op_dec),
    .op_addr   (op_wr_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_user  (req_user),
    .req_write (req_write),
    .busy      (busy),
    .rsp_take  (rsp_take),
    .op_err    (op_err)
  );

  xrr_result #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_res (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rsp_take  (rsp_take),
    .rsp_paddr (rsp_paddr),
    .rsp_attr  (rsp_attr),
    .rsp_fault (rsp_fault),
    .rsp_ext   (rsp_ext),
    .rsp_fs_hi (rsp_fs_hi),
    .rsp_fs_lo (rsp_fs_lo),
    .sw_wr     (res_wr),
    .sw_data   (res_wdata),
    .busy      (busy),
    .res_q     (res_q)
  );
endmodule

// File: rtl/xrr_checker.sv
module xrr_checker #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 3,
  parameter int NUM_OPS   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_wr_valid,
  input logic [IDX_W-1:0]     op_wr_idx,
  input logic [ADDR_W-1:0]    op_wr_addr,
  input logic                 op_err,
  input logic                 busy,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [ADDR_W-1:0]    req_vaddr,
  input logic                 req_user,
  input logic                 req_write,
  input logic                 rsp_valid,
  input logic [ADDR_W-1:0]    rsp_paddr,
  input logic                 rsp_fault,
  input logic                 rsp_ext,
  input logic                 res_wr,
  input logic [ADDR_W-1:0]    res_wdata,
  input logic [ADDR_W-1:0]    res_q
);
  logic waiting;
  logic good_idx;
  assign waiting  = busy && !req_valid;
  assign good_idx = (op_wr_idx < IDX_W'(NUM_OPS));

  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_valid && !busy && good_idx) |=>
      (req_valid && req_write == $past(op_wr_idx[0]) &&
       req_user == $past(op_wr_idx[1]) && req_vaddr == $past(op_wr_addr)));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_vaddr) && $stable(req_user) && $stable(req_write)));

  a_r2_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_valid && !busy && !good_idx) |=> (op_err && !busy && !req_valid));

  a_r3_success: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rsp_valid && !rsp_fault) |=>
      (res_q[0] == 1'b0 && res_q[ADDR_W-1:PAGE_BITS] == $past(rsp_paddr[ADDR_W-1:PAGE_BITS])));

  a_r4_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rsp_valid && rsp_fault) |=> (res_q[0] && res_q[6] == $past(rsp_ext)));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(waiting && rsp_valid)) |=> $stable(res_q));

  a_r6_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_wr_valid) |=> !op_err);

  a_r7_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr && !busy) |=> (res_q == $past(res_wdata)));

  a_r9_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rsp_valid && !res_wr) |=> $stable(res_q));
endmodule

bind xrr_top xrr_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .NUM_OPS(NUM_OPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .op_wr_valid (op_wr_valid),
  .op_wr_idx   (op_wr_idx),
  .op_wr_addr  (op_wr_addr),
  .op_err      (op_err),
  .busy        (busy),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .req_user    (req_user),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_fault   (rsp_fault),
  .rsp_ext     (rsp_ext),
  .res_wr      (res_wr),
  .res_wdata   (res_wdata),
  .res_q       (res_q)
);

// File: tb/xrr_top_bench.sv
`timescale 1ns/1ps
module xrr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_wr_valid;
  logic [2:0]  op_wr_idx;
  logic [31:0] op_wr_addr;
  logic        op_err, busy, req_valid, req_ready, req_user, req_write;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_fault, rsp_ext, rsp_fs_hi;
  logic [31:0] rsp_paddr;
  logic [10:0] rsp_attr;
  logic [3:0]  rsp_fs_lo;
  logic        res_wr;
  logic [31:0] res_wdata, res_q;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_res;

  always #2.5 clk = ~clk;

  xrr_top u_xrr_top (
    .clk(clk), .rst_n(rst_n), .op_wr_valid(op_wr_valid), .op_wr_idx(op_wr_idx),
    .op_wr_addr(op_wr_addr), .op_err(op_err), .busy(busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_attr(rsp_attr), .rsp_fault(rsp_fault), .rsp_ext(rsp_ext),
    .rsp_fs_hi(rsp_fs_hi), .rsp_fs_lo(rsp_fs_lo), .res_wr(res_wr),
    .res_wdata(res_wdata), .res_q(res_q)
  );

  function automatic logic [31:0] ok_val(input logic [31:0] pa, input logic [10:0] at);
    return {pa[31:12], at, 1'b0};
  endfunction

  function automatic logic [31:0] flt_val(input logic e, input logic h, input logic [3:0] l);
    logic [31:0] v;
    v    = 32'd0;
    v[0] = 1'b1;
    v[4:1] = l;
    v[5] = h;
    v[6] = e;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_res = 32'd0;
  endtask

  task automatic run_op(input logic [2:0] idx, input logic [31:0] va,
                        input int rdy_dly, input int rsp_dly, input bit poke);
    logic [31:0] pa;
    logic [10:0] at;
    logic        f, e, h;
    logic [3:0]  l;
    pa = $urandom; at = 11'($urandom); f = 1'($urandom);
    e = 1'($urandom); h = 1'($urandom); l = 4'($urandom);
    @(negedge clk);
    op_wr_valid = 1'b1; op_wr_idx = idx; op_wr_addr = va;
    @(negedge clk);
    op_wr_valid = 1'b0;
    if (idx >= 3'd4) begin
      chk(op_err == 1'b1, "R2 err pulse", {31'd0, op_err}, 32'd1);
      chk(!req_valid && !busy, "R2 no request", {30'd0, req_valid, busy}, 32'd0);
      chk(res_q == exp_res, "R2 result kept", res_q, exp_res);
      @(negedge clk);
      chk(op_err == 1'b0, "R2 single pulse", {31'd0, op_err}, 32'd0);
      return;
    end
    chk(req_valid && busy, "R1 R6 request up", {30'd0, req_valid, busy}, 32'd3);
    chk(req_vaddr == va, "R1 vaddr", req_vaddr, va);
    chk({req_user, req_write} == idx[1:0], "R1 flags", {30'd0, req_user, req_write},
        {30'd0, idx[1:0]});
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk(req_valid && req_vaddr == va, "R1 hold", {31'd0, req_valid}, 32'd1);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(!req_valid && busy, "R1 R6 handshake done", {30'd0, req_valid, busy}, 32'd1);
    if (poke) begin
      op_wr_valid = 1'b1; op_wr_idx = 3'($urandom); op_wr_addr = $urandom;
      res_wr = 1'b1; res_wdata = $urandom;
      @(negedge clk);
      op_wr_valid = 1'b0; res_wr = 1'b0;
      chk(res_q == exp_res, "R7 busy write ignored", res_q, exp_res);
      chk(!op_err && !req_valid, "R6 op held off", {30'd0, op_err, req_valid}, 32'd0);
    end
    for (int i = 0; i < rsp_dly; i++) @(negedge clk);
    chk(res_q == exp_res, "R5 result held", res_q, exp_res);
    rsp_valid = 1'b1; rsp_paddr = pa; rsp_attr = at; rsp_fault = f;
    rsp_ext = e; rsp_fs_hi = h; rsp_fs_lo = l;
    @(negedge clk);
    rsp_valid = 1'b0;
    exp_res = f ? flt_val(e, h, l) : ok_val(pa, at);
    if (f) chk(res_q == exp_res, "R4 fault pack", res_q, exp_res);
    else   chk(res_q == exp_res, "R3 success pack", res_q, exp_res);
    chk(!busy, "R6 busy clear", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(!req_valid && !busy, "R6 no late request", {30'd0, req_valid, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    op_wr_valid = 0; op_wr_idx = 0; op_wr_addr = 0; req_ready = 0;
    rsp_valid = 0; rsp_paddr = 0; rsp_attr = 0; rsp_fault = 0; rsp_ext = 0;
    rsp_fs_hi = 0; rsp_fs_lo = 0; res_wr = 0; res_wdata = 0;
    do_reset();
    chk(res_q == 32'd0 && !busy && !req_valid && !op_err, "R8 reset state",
        res_q, 32'd0);

    // R7 direct load while idle
    @(negedge clk); res_wr = 1'b1; res_wdata = 32'hA5C3_0F1E;
    @(negedge clk); res_wr = 1'b0; exp_res = 32'hA5C3_0F1E;
    chk(res_q == exp_res, "R7 idle load", res_q, exp_res);

    // R9 stray response while idle
    rsp_valid = 1'b1; rsp_paddr = 32'hFFFF_FFFF; rsp_attr = '1; rsp_fault = 1'b0;
    @(negedge clk); rsp_valid = 1'b0;
    chk(res_q == exp_res && !busy, "R9 stray response", res_q, exp_res);

    // directed: each supported slot, unsupported slots at both ends
    run_op(3'd0, 32'h1234_5678, 0, 0, 1'b0);
    run_op(3'd1, 32'hDEAD_B000, 3, 2, 1'b1);
    run_op(3'd2, 32'h0000_0FFF, 1, 0, 1'b0);
    run_op(3'd3, 32'hFFFF_F000, 0, 4, 1'b1);
    run_op(3'd4, 32'h4444_4444, 0, 0, 1'b0);
    run_op(3'd7, 32'h7777_7777, 0, 0, 1'b0);

    // R8 reset in the middle of a request
    @(negedge clk); op_wr_valid = 1'b1; op_wr_idx = 3'd1; op_wr_addr = 32'h5555_0000;
    @(negedge clk); op_wr_valid = 1'b0;
    rst_n = 1'b0; #1;
    chk(!req_valid && !busy && res_q == 32'd0, "R8 reset mid lookup",
        {29'd0, req_valid, busy, |res_q}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_res = 32'd0;
    chk(!req_valid && !busy, "R8 request dropped", {30'd0, req_valid, busy}, 32'd0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      run_op(3'($urandom), $urandom, int'($urandom % 4), int'($urandom % 4),
             1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule